// File: doc/BRIEF.md
# Paired-lane single-precision adder with exception status

This block adds two floating-point operands held in 64-bit operand registers. A format select chooses the mode. In scalar mode only the low 32-bit single-precision values are added. In paired mode the upper and lower 32-bit halves are added as two independent lanes. Each lane forms the exact sum and rounds it once, using a 2-bit rounding mode supplied from the control/status register.

Each operation produces a 5-bit cause vector, which merges both lanes in paired mode. The cause vector is compared against the trap enables to decide whether the operation traps. A trapping operation does not write its destination and leaves the sticky flags alone. A non-trapping operation ORs its causes into the sticky flags.

The unit accepts one operation per cycle. The result, the cause vector, the trap decision and a write strobe appear together one clock edge after acceptance.

Top module: `fpadd_paired`

## Requirements
- R1: With `paired_i`=0 the low lanes are added and `result_o[63:32]` is zero. Upper-lane operands, including NaN or denormal values, never affect the result or the causes.
- R2: With `paired_i`=1 the upper and lower 32-bit halves are summed independently, each as the correctly rounded exact sum.
- R3: In paired mode `cause_o` is the bitwise OR of the two lane cause vectors. Cause bit positions are 4 unimplemented, 3 invalid, 2 overflow, 1 underflow, 0 inexact.
- R4: `rm_i` selects rounding: 0 to nearest with ties to even, 1 toward zero, 2 toward +infinity, 3 toward -infinity. Any discarded nonzero bits set inexact.
- R5: On exponent overflow, overflow and inexact are set. The result is infinity when rounding to nearest or rounding away from zero in the result's direction. Otherwise it is the largest finite value of the result's sign.
- R6: A denormal operand, or a nonzero sum below the normal range, sets only the unimplemented cause and returns 0x7FBFFFFF. It always traps.
- R7: Infinities of opposite sign, or a NaN with fraction bit 22 set (signalling), set invalid and return 0x7FBFFFFF. A NaN with fraction bit 22 clear (quiet) returns 0x7FBFFFFF with no cause. Infinity plus a finite value returns that infinity.
- R8: A zero sum of opposite-signed values is +0, or -0 when `rm_i`=3. Two zeros of equal sign keep that sign. Zero plus x returns x exactly.
- R9: `trap_o` is set when the unimplemented cause is set, or when a cause in bits 3:0 has its enable set. `trap_en_i` uses the same positions as cause bits 3:0. `wr_o` is `valid_o` with no trap.
- R10: `flags_o` (same positions as cause bits 3:0) is reset to zero and never clears. It gains the operation's cause bits only when that operation does not trap.
- R11: `ready_o` is always high. An operation accepted with `valid_i` at a clock edge presents its outputs with `valid_o` high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation request |
| ready_o | output | 1 | Unit can accept (always high) |
| paired_i | input | 1 | 1 = two-lane mode, 0 = scalar |
| rm_i | input | 2 | Rounding mode |
| trap_en_i | input | 4 | Trap enables {invalid, overflow, underflow, inexact} |
| opa_i | input | 64 | First operand register |
| opb_i | input | 64 | Second operand register |
| valid_o | output | 1 | Result-valid pulse |
| result_o | output | 64 | Sum, upper lane in bits 63:32 |
| cause_o | output | 5 | Merged cause vector |
| trap_o | output | 1 | Operation traps |
| wr_o | output | 1 | Destination write strobe |
| flags_o | output | 4 | Sticky flags {invalid, overflow, underflow, inexact} |

## Verification
The trap decision and the sticky flag update are settled at the same clock edge from the same cause vector. A wrong gate between them therefore shows only when causes and enables coincide. The bench runs one sequence after a fresh reset that alternates inexact, overflow and invalid operations with matching and non-matching enables, including an always-trapping denormal. After each operation it compares `trap_o`, `wr_o` and the whole `flags_o` word with values accumulated by hand.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned FRAC_W = 23;
  localparam int unsigned LANE_W = 1 + EXP_W + FRAC_W;
  localparam int unsigned GRS_W  = 3;
  localparam int unsigned MAN_W  = FRAC_W + 1;
  localparam int unsigned EXT_W  = MAN_W + GRS_W;
  localparam int unsigned EW2    = EXP_W + 2;
  localparam int unsigned LZW    = $clog2(EXT_W + 1);
  localparam int unsigned CAUSE_W = 5;
  localparam int unsigned FLAG_W  = 4;

  localparam int unsigned C_INX = 0;
  localparam int unsigned C_UNF = 1;
  localparam int unsigned C_OVF = 2;
  localparam int unsigned C_INV = 3;
  localparam int unsigned C_UNI = 4;

  localparam logic [LANE_W-1:0] QNAN_DFLT = 32'h7FBF_FFFF;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/fpadd_round.sv
module fpadd_round
  import fpadd_pkg::*;
(
  input  logic                     sign_i,
  input  logic signed [EW2-1:0]    exp_i,
  input  logic [EXT_W-1:0]         man_i,
  input  rmode_e                   rm_i,
  output logic [LANE_W-1:0]        res_o,
  output logic                     ovf_o,
  output logic                     inx_o
);
  logic              guard, sticky, inc, to_inf;
  logic [MAN_W-1:0]  kept;
  logic [MAN_W:0]    rnd;
  logic signed [EW2-1:0] exp_r;

  assign kept   = man_i[EXT_W-1:GRS_W];
  assign guard  = man_i[GRS_W-1];
  assign sticky = |man_i[GRS_W-2:0];

  always_comb begin
    unique case (rm_i)
      RM_NEAR: inc = guard & (sticky | kept[0]);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = (guard | sticky) & ~sign_i;
      default: inc = (guard | sticky) & sign_i;
    endcase
  end

  assign rnd   = {1'b0, kept} + {{MAN_W{1'b0}}, inc};
  assign exp_r = exp_i + $signed({{(EW2-1){1'b0}}, rnd[MAN_W]});
  assign ovf_o = exp_r >= $signed({2'b00, {EXP_W{1'b1}}});
  assign inx_o = guard | sticky | ovf_o;
  assign to_inf = (rm_i == RM_NEAR) || (rm_i == RM_UP && !sign_i) ||
                  (rm_i == RM_DOWN && sign_i);

  always_comb begin
    if (ovf_o) begin
      if (to_inf) res_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      else        res_o = {sign_i, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    end else begin
      res_o = {sign_i, exp_r[EXP_W-1:0], rnd[FRAC_W-1:0]};
    end
  end
endmodule

// File: rtl/fpadd_lane.sv
module fpadd_lane
  import fpadd_pkg::*;
(
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  rmode_e            rm_i,
  output logic [LANE_W-1:0] res_o,
  output cause_t            cause_o
);
  logic              sa, sb, sl, ss;
  logic [EXP_W-1:0]  ea, eb, el, es, d;
  logic [FRAC_W-1:0] fa, fb, fl, fsm;
  logic a_zero, b_zero, a_den, b_den, a_inf, b_inf, a_nan, b_nan, a_snan, b_snan;
  logic a_big, stk, tiny;
  logic [EXT_W-1:0]  ml, ms, ms_sh, bx, nrm;
  logic [EXT_W:0]    sum;
  logic [LZW-1:0]    lz;
  logic signed [EW2-1:0] exp_n;
  logic [LANE_W-1:0] rnd_res;
  logic              rnd_ovf, rnd_inx;

  function automatic logic [LZW-1:0] lzc(input logic [EXT_W-1:0] v);
    lzc = LZW'(EXT_W);
    for (int i = 0; i < EXT_W; i++)
      if (v[i]) lzc = LZW'(EXT_W - 1 - i);
  endfunction

  assign {sa, ea, fa} = a_i;
  assign {sb, eb, fb} = b_i;

  assign a_zero = (ea == '0) && (fa == '0);
  assign b_zero = (eb == '0) && (fb == '0);
  assign a_den  = (ea == '0) && (fa != '0);
  assign b_den  = (eb == '0) && (fb != '0);
  assign a_inf  = (&ea) && (fa == '0);
  assign b_inf  = (&eb) && (fb == '0);
  assign a_nan  = (&ea) && (fa != '0);
  assign b_nan  = (&eb) && (fb != '0);
  // fraction MSB set marks a signalling NaN in this encoding
  assign a_snan = a_nan && fa[FRAC_W-1];
  assign b_snan = b_nan && fb[FRAC_W-1];

  assign a_big = {ea, fa} >= {eb, fb};

  always_comb begin
    if (a_big) begin
      sl = sa; el = ea; fl = fa; ss = sb; es = eb; fsm = fb;
    end else begin
      sl = sb; el = eb; fl = fb; ss = sa; es = ea; fsm = fa;
    end
  end

  assign ml = {1'b1, fl,  {GRS_W{1'b0}}};
  assign ms = {1'b1, fsm, {GRS_W{1'b0}}};
  assign d  = el - es;

  always_comb begin
    if (d >= EXP_W'(EXT_W)) begin
      ms_sh = '0;
      stk   = |ms;
    end else begin
      ms_sh = ms >> d;
      stk   = |(ms & ~({EXT_W{1'b1}} << d));
    end
  end

  assign bx  = {ms_sh[EXT_W-1:1], ms_sh[0] | stk};
  assign sum = (sl ^ ss) ? ({1'b0, ml} - {1'b0, bx}) : ({1'b0, ml} + {1'b0, bx});
  assign lz  = lzc(sum[EXT_W-1:0]);

  always_comb begin
    if (sum[EXT_W]) begin
      nrm   = {sum[EXT_W:2], sum[1] | sum[0]};
      exp_n = $signed({2'b00, el}) + $signed(EW2'(1));
    end else begin
      nrm   = sum[EXT_W-1:0] << lz;
      exp_n = $signed({2'b00, el}) - $signed({{(EW2-LZW){1'b0}}, lz});
    end
  end

  assign tiny = exp_n <= $signed(EW2'(0));

  fpadd_round u_round (
    .sign_i (sl),
    .exp_i  (exp_n),
    .man_i  (nrm),
    .rm_i   (rm_i),
    .res_o  (rnd_res),
    .ovf_o  (rnd_ovf),
    .inx_o  (rnd_inx)
  );

  always_comb begin
    cause_o = '0;
    res_o   = rnd_res;
    if (a_den || b_den) begin
      cause_o[C_UNI] = 1'b1;
      res_o          = QNAN_DFLT;
    end else if (a_nan || b_nan) begin
      cause_o[C_INV] = a_snan | b_snan;
      res_o          = QNAN_DFLT;
    end else if (a_inf || b_inf) begin
      if (a_inf && b_inf && (sa != sb)) begin
        cause_o[C_INV] = 1'b1;
        res_o          = QNAN_DFLT;
      end else begin
        res_o = a_inf ? a_i : b_i;
      end
    end else if (a_zero && b_zero) begin
      res_o = (sa == sb) ? a_i : {rm_i == RM_DOWN, {(LANE_W-1){1'b0}}};
    end else if (a_zero) begin
      res_o = b_i;
    end else if (b_zero) begin
      res_o = a_i;
    end else if (sum == '0) begin
      res_o = {rm_i == RM_DOWN, {(LANE_W-1){1'b0}}};
    end else if (tiny) begin
      cause_o[C_UNI] = 1'b1;
      res_o          = QNAN_DFLT;
    end else begin
      cause_o[C_OVF] = rnd_ovf;
      cause_o[C_INX] = rnd_inx;
    end
  end
endmodule

// File: rtl/fpadd_status.sv
module fpadd_status
  import fpadd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  cause_t            cause_i,
  input  logic [FLAG_W-1:0] en_i,
  output logic              trap_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic [FLAG_W-1:0] flags_q;

  assign trap_o = cause_i[C_UNI] | (|(cause_i[FLAG_W-1:0] & en_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flags_q <= '0;
    else if (fire_i && !trap_o) flags_q <= flags_q | cause_i[FLAG_W-1:0];
  end

  assign flags_o = flags_q;

  AST_FLAGS_NEVER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(flags_q) & ~flags_q) == '0)); // R10
endmodule

// File: rtl/fpadd_paired.sv
module fpadd_paired
  import fpadd_pkg::*;
#(
  parameter int unsigned NUM_LANES = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  output logic                          ready_o,
  input  logic                          paired_i,
  input  logic [1:0]                    rm_i,
  input  logic [FLAG_W-1:0]             trap_en_i,
  input  logic [NUM_LANES*LANE_W-1:0]   opa_i,
  input  logic [NUM_LANES*LANE_W-1:0]   opb_i,
  output logic                          valid_o,
  output logic [NUM_LANES*LANE_W-1:0]   result_o,
  output logic [CAUSE_W-1:0]            cause_o,
  output logic                          trap_o,
  output logic                          wr_o,
  output logic [FLAG_W-1:0]             flags_o
);
  localparam int unsigned DATA_W = NUM_LANES * LANE_W;

  rmode_e            rm;
  logic [DATA_W-1:0] res_d, res_q;
  cause_t            lane_cause [NUM_LANES];
  cause_t            cause_d, cause_q;
  logic              trap_d, trap_q, valid_q, paired_q;

  assign rm      = rmode_e'(rm_i);
  assign ready_o = 1'b1;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic              act;
    logic [LANE_W-1:0] lres;
    // scalar mode keeps only lane 0
    assign act = paired_i || (i == 0);
    fpadd_lane u_lane (
      .a_i     (opa_i[i*LANE_W +: LANE_W]),
      .b_i     (opb_i[i*LANE_W +: LANE_W]),
      .rm_i    (rm),
      .res_o   (lres),
      .cause_o (lane_cause[i])
    );
    assign res_d[i*LANE_W +: LANE_W] = act ? lres : '0;
  end

  always_comb begin
    cause_d = '0;
    for (int i = 0; i < NUM_LANES; i++)
      if (paired_i || i == 0) cause_d = cause_d | lane_cause[i];
  end

  fpadd_status u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (valid_i),
    .cause_i (cause_d),
    .en_i    (trap_en_i),
    .trap_o  (trap_d),
    .flags_o (flags_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      res_q    <= '0;
      cause_q  <= '0;
      trap_q   <= 1'b0;
      paired_q <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        res_q    <= res_d;
        cause_q  <= cause_d;
        trap_q   <= trap_d;
        paired_q <= paired_i;
      end
    end
  end

  assign valid_o  = valid_q;
  assign result_o = res_q;
  assign cause_o  = cause_q;
  assign trap_o   = trap_q;
  assign wr_o     = valid_q & ~trap_q;

  AST_OUT_FOLLOWS_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i)); // R11
  AST_UNIMPL_TRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && cause_o[C_UNI] |-> trap_o && !wr_o); // R6
  AST_FLAGS_HELD_ON_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && trap_o |-> flags_o == $past(flags_o)); // R10
  AST_FLAGS_GATHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !trap_o |-> flags_o == ($past(flags_o) | cause_o[FLAG_W-1:0])); // R9
  AST_SCALAR_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !paired_q |-> result_o[DATA_W-1:LANE_W] == '0); // R1
endmodule

// File: tb/tb_fpadd_paired.sv
`timescale 1ns/1ps
module tb_fpadd_paired;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        ready_o;
  logic        paired_i = 1'b0;
  logic [1:0]  rm_i = 2'd0;
  logic [3:0]  trap_en_i = 4'd0;
  logic [63:0] opa_i = '0, opb_i = '0;
  logic        valid_o;
  logic [63:0] result_o;
  logic [4:0]  cause_o;
  logic        trap_o, wr_o;
  logic [3:0]  flags_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  fpadd_paired dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .ready_o(ready_o),
    .paired_i(paired_i), .rm_i(rm_i), .trap_en_i(trap_en_i),
    .opa_i(opa_i), .opb_i(opb_i), .valid_o(valid_o), .result_o(result_o),
    .cause_o(cause_o), .trap_o(trap_o), .wr_o(wr_o), .flags_o(flags_o)
  );

  typedef struct packed {
    logic        p;
    logic [1:0]  rm;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] res;
    logic [4:0]  cause;
    logic        trap;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 64'h40800000_3F800000, 64'h7FC00000_40000000, 64'h00000000_40400000, 5'h00, 1'b0, 8'd1}, // R1
    '{1'b1, 2'd0, 64'h3F800000_40400000, 64'h3F000000_BF800000, 64'h3FC00000_40000000, 5'h00, 1'b0, 8'd2}, // R2
    '{1'b1, 2'd0, 64'h40000000_3F800000, 64'h40000000_B3800000, 64'h40800000_3F7FFFFF, 5'h00, 1'b0, 8'd2}, // R2
    '{1'b0, 2'd0, 64'h0_3F800000, 64'h0_33800000, 64'h0_3F800000, 5'h01, 1'b0, 8'd4}, // R4 tie to even
    '{1'b0, 2'd1, 64'h0_3F800000, 64'h0_33800000, 64'h0_3F800000, 5'h01, 1'b0, 8'd4}, // R4
    '{1'b0, 2'd2, 64'h0_3F800000, 64'h0_33800000, 64'h0_3F800001, 5'h01, 1'b0, 8'd4}, // R4
    '{1'b0, 2'd3, 64'h0_BF800000, 64'h0_B3800000, 64'h0_BF800001, 5'h01, 1'b0, 8'd4}, // R4
    '{1'b0, 2'd2, 64'h0_BF800000, 64'h0_B3800000, 64'h0_BF800000, 5'h01, 1'b0, 8'd4}, // R4
    '{1'b0, 2'd0, 64'h0_3F800000, 64'h0_33C00000, 64'h0_3F800001, 5'h01, 1'b0, 8'd4}, // R4 above half
    '{1'b0, 2'd0, 64'h0_3F800000, 64'h0_B3000000, 64'h0_3F800000, 5'h01, 1'b0, 8'd4}, // R4 carry after round
    '{1'b0, 2'd1, 64'h0_3F800000, 64'h0_B3000000, 64'h0_3F7FFFFF, 5'h01, 1'b0, 8'd4}, // R4
    '{1'b0, 2'd0, 64'h0_7F7FFFFF, 64'h0_7F7FFFFF, 64'h0_7F800000, 5'h05, 1'b0, 8'd5}, // R5
    '{1'b0, 2'd1, 64'h0_7F7FFFFF, 64'h0_7F7FFFFF, 64'h0_7F7FFFFF, 5'h05, 1'b0, 8'd5}, // R5
    '{1'b0, 2'd3, 64'h0_FF7FFFFF, 64'h0_FF7FFFFF, 64'h0_FF800000, 5'h05, 1'b0, 8'd5}, // R5
    '{1'b0, 2'd2, 64'h0_FF7FFFFF, 64'h0_FF7FFFFF, 64'h0_FF7FFFFF, 5'h05, 1'b0, 8'd5}, // R5
    '{1'b0, 2'd0, 64'h0_7F800000, 64'h0_FF800000, 64'h0_7FBFFFFF, 5'h08, 1'b0, 8'd7}, // R7
    '{1'b0, 2'd0, 64'h0_7FC00000, 64'h0_3F800000, 64'h0_7FBFFFFF, 5'h08, 1'b0, 8'd7}, // R7
    '{1'b0, 2'd0, 64'h0_7FBFFFFF, 64'h0_3F800000, 64'h0_7FBFFFFF, 5'h00, 1'b0, 8'd7}, // R7
    '{1'b0, 2'd0, 64'h0_7F800000, 64'h0_3F800000, 64'h0_7F800000, 5'h00, 1'b0, 8'd7}, // R7
    '{1'b0, 2'd0, 64'h0_3F800000, 64'h0_BF800000, 64'h0_00000000, 5'h00, 1'b0, 8'd8}, // R8
    '{1'b0, 2'd3, 64'h0_3F800000, 64'h0_BF800000, 64'h0_80000000, 5'h00, 1'b0, 8'd8}, // R8
    '{1'b0, 2'd0, 64'h0_80000000, 64'h0_80000000, 64'h0_80000000, 5'h00, 1'b0, 8'd8}, // R8
    '{1'b0, 2'd0, 64'h0_00000000, 64'h0_3F800000, 64'h0_3F800000, 5'h00, 1'b0, 8'd8}, // R8
    '{1'b0, 2'd3, 64'h0_00000000, 64'h0_80000000, 64'h0_80000000, 5'h00, 1'b0, 8'd8}, // R8
    '{1'b0, 2'd0, 64'h0_00000001, 64'h0_3F800000, 64'h0_7FBFFFFF, 5'h10, 1'b1, 8'd6}, // R6
    '{1'b0, 2'd0, 64'h0_00800001, 64'h0_80800000, 64'h0_7FBFFFFF, 5'h10, 1'b1, 8'd6}, // R6
    '{1'b1, 2'd0, 64'h7F7FFFFF_7F800000, 64'h7F7FFFFF_FF800000, 64'h7F800000_7FBFFFFF, 5'h0D, 1'b0, 8'd3}, // R3
    '{1'b1, 2'd0, 64'h3F800000_3F800000, 64'h33800000_3F800000, 64'h3F800000_40000000, 5'h01, 1'b0, 8'd3}, // R3
    '{1'b1, 2'd0, 64'h00000001_3F800000, 64'h3F800000_3F800000, 64'h7FBFFFFF_40000000, 5'h10, 1'b1, 8'd3}, // R3
    '{1'b0, 2'd0, 64'h00000001_3F800000, 64'h00000001_3F800000, 64'h00000000_40000000, 5'h00, 1'b0, 8'd1}  // R1
  };

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input logic p, input logic [1:0] rm, input logic [3:0] en,
                       input logic [63:0] a, input logic [63:0] b);
    @(negedge clk_i);
    valid_i = 1'b1; paired_i = p; rm_i = rm; trap_en_i = en; opa_i = a; opb_i = b;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL R11 watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk_i);
    // reset state
    chk("R11", "valid_o at reset", 64'(valid_o), 64'd0);
    chk("R10", "flags_o at reset", 64'(flags_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11", "ready_o", 64'(ready_o), 64'd1);
    chk("R11", "idle valid_o", 64'(valid_o), 64'd0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      do_op(VECS[i].p, VECS[i].rm, 4'd0, VECS[i].a, VECS[i].b);
      chk(tag, "result", result_o, VECS[i].res);
      chk(tag, "cause", 64'(cause_o), 64'(VECS[i].cause));
      chk(tag, "trap", 64'(trap_o), 64'(VECS[i].trap));
      chk(tag, "wr", 64'(wr_o), 64'(!VECS[i].trap));
    end

    // R11: one-cycle output pulse
    do_op(1'b0, 2'd0, 4'd0, 64'h0_3F800000, 64'h0_3F800000);
    chk("R11", "valid_o pulse", 64'(valid_o), 64'd1);
    @(negedge clk_i);
    chk("R11", "valid_o drops", 64'(valid_o), 64'd0);

    // R9 / R10: trap gating of sticky flags from a fresh reset
    do_reset();
    chk("R10", "flags after reset", 64'(flags_o), 64'd0);
    do_op(1'b0, 2'd0, 4'b0000, 64'h0_3F800000, 64'h0_33800000);
    chk("R10", "inexact collected", 64'(flags_o), 64'h1);
    chk("R9", "no trap", 64'(trap_o), 64'd0);
    do_op(1'b0, 2'd0, 4'b0100, 64'h0_7F7FFFFF, 64'h0_7F7FFFFF);
    chk("R9", "overflow trap", 64'(trap_o), 64'd1);
    chk("R9", "no write on trap", 64'(wr_o), 64'd0);
    chk("R10", "flags held on trap", 64'(flags_o), 64'h1);
    do_op(1'b0, 2'd0, 4'b0000, 64'h0_7F800000, 64'h0_FF800000);
    chk("R10", "invalid collected", 64'(flags_o), 64'h9);
    chk("R9", "write without trap", 64'(wr_o), 64'd1);
    do_op(1'b0, 2'd0, 4'b0001, 64'h0_3F800000, 64'h0_33800000);
    chk("R9", "inexact trap", 64'(trap_o), 64'd1);
    chk("R10", "flags held inexact trap", 64'(flags_o), 64'h9);
    do_op(1'b1, 2'd0, 4'b0000, 64'h00000001_3F800000, 64'h3F800000_3F800000);
    chk("R6", "unimplemented traps", 64'(trap_o), 64'd1);
    chk("R10", "flags held unimplemented", 64'(flags_o), 64'h9);
    do_op(1'b1, 2'd0, 4'b1000, 64'h7F7FFFFF_3F800000, 64'h7F7FFFFF_3F800000);
    chk("R9", "merged overflow enable off", 64'(trap_o), 64'd0);
    chk("R10", "overflow from upper lane", 64'(flags_o), 64'hD);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule